// File: doc/BRIEF.md
# Command FIFO Pointer Controller

This block tracks a circular command buffer that lives in system memory and feeds a graphics command processor. It holds no command data itself: it keeps the buffer's first and last unit addresses, a write pointer that the CPU side advances, a read pointer that the command parser consumes from, and a count of the units outstanding between them. Both pointers move in 32-byte units and jump from the last unit back to the first. The move happens on the unit that equals the top address, so the top address itself is a valid unit.

Two programmable watermarks raise sticky overflow and underflow flags. A breakpoint address stops the parser at a chosen read position until software releases it. Each of the three flags has its own interrupt enable, and the block drives one combined interrupt line. Software sees everything through a 16-bit register port. Every 32-bit quantity occupies two consecutive halves: the low half comes first and the high half sits 2 bytes above it.

Top module: `cmd_fifo_ptr_ctrl`

## Requirements
- R1: After reset the control register reads 0x0010: only write-advance (bit 4) is set. Count, watermarks and all pointers read 0. With `rd_req` low and `parser_idle` high, status reads 0x000C, and `irq` is low.
- R2: Register word offsets are as follows. Status is at 0x00 and control at 0x02. Clear is at 0x04; it is write-only and reads 0. First unit is at 0x20, last unit at 0x24, high watermark at 0x28, low watermark at 0x2C, count at 0x30, write pointer at 0x34, read pointer at 0x38 and breakpoint at 0x3C. Each 32-bit value has its low half at its offset and its high half at offset+2. The five address registers (first, last, write, read, breakpoint) force their low 5 bits to 0, so writing 0x1234 reads back 0x1220.
- R3: A `cpu_push` pulse while control bit 4 is 1 moves the write pointer forward by 32 and raises the count by 1. While bit 4 is 0, a push changes neither.
- R4: A pointer that equals the last-unit address moves to the first-unit address on its next advance. This applies to both the write pointer and the read pointer.
- R5: `rd_grant` is high when all of the following hold: `rd_req` is high, control bit 0 is set, the count is non-zero and no breakpoint is hit. A grant moves the read pointer by one unit and lowers the count by 1. `rd_addr` always shows the read pointer.
- R6: A push and a grant in the same cycle move both pointers and leave the count unchanged.
- R7: Status bit 0 is set one cycle after the count exceeds the high watermark. It stays set until a write of 1 to clear-register bit 0, and that write only takes effect while the count no longer exceeds the watermark.
- R8: Status bit 1 is set one cycle after the count is below the low watermark. A write of 1 to clear-register bit 1 clears it only while the count is no longer below the watermark.
- R9: Control bit 1 arms the breakpoint. When it is armed and the read pointer equals the breakpoint address, grants stop and status bit 4 is set one cycle later. Writes to the clear register do not clear bit 4. Only a control write with bit 1 at 0 clears it.
- R10: Status bit 2 is the inverse of `rd_req`. Status bit 3 is high when bit 2 is high, `parser_idle` is high and the count is 0.
- R11: `irq` is high whenever at least one of these pairs is set: status bit 0 with control bit 2, status bit 1 with control bit 3, or status bit 4 with control bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe for one 16-bit half |
| reg_addr | input | 8 | Byte offset of the register half |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| cpu_push | input | 1 | One unit written into the buffer by the CPU side |
| rd_req | input | 1 | Parser asks to consume one unit |
| rd_grant | output | 1 | Consumption accepted this cycle |
| rd_addr | output | 32 | Current read pointer |
| parser_idle | input | 1 | Command parser has no work in progress |
| ovf_flag | output | 1 | Sticky high-watermark flag |
| udf_flag | output | 1 | Sticky low-watermark flag |
| bp_flag | output | 1 | Breakpoint reached flag |
| irq | output | 1 | Combined enabled interrupt |

## Verification
The function pair that can collide is the producer push and the consumer grant. When they land in the same cycle, the count update must cancel while both pointers still advance. The bench provokes this with a single cycle that raises `cpu_push` and `rd_req` together on a non-empty buffer. It then reads back the count and both pointers and compares them with values worked out by hand from the two unit steps. A second collision is between a flag that is still true and the software write that clears it. The bench writes the clear while the watermark condition still holds and expects the flag to survive.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
  localparam int BUS_W  = 16;
  localparam int REG_W  = 2 * BUS_W;
  localparam int REG_AW = 8;
  localparam int CTRL_W = 6;

  localparam logic [REG_AW-1:0] OFS_STAT = 8'h00;
  localparam logic [REG_AW-1:0] OFS_CTRL = 8'h02;
  localparam logic [REG_AW-1:0] OFS_CLR  = 8'h04;
  localparam logic [REG_AW-1:0] OFS_BASE = 8'h20;
  localparam logic [REG_AW-1:0] OFS_TOP  = 8'h24;
  localparam logic [REG_AW-1:0] OFS_HIWM = 8'h28;
  localparam logic [REG_AW-1:0] OFS_LOWM = 8'h2C;
  localparam logic [REG_AW-1:0] OFS_CNT  = 8'h30;
  localparam logic [REG_AW-1:0] OFS_WPTR = 8'h34;
  localparam logic [REG_AW-1:0] OFS_RPTR = 8'h38;
  localparam logic [REG_AW-1:0] OFS_BRK  = 8'h3C;

  // control bit positions (software decodes them)
  localparam int CB_RDEN  = 0;
  localparam int CB_BPEN  = 1;
  localparam int CB_OVFIE = 2;
  localparam int CB_UDFIE = 3;
  localparam int CB_WPINC = 4;
  localparam int CB_BPIE  = 5;
  localparam logic [CTRL_W-1:0] CTRL_RST = 6'b01_0000;

  // clear register bit positions
  localparam int CL_OVF = 0;
  localparam int CL_UDF = 1;

  // next unit address with wrap from last unit back to first
  function automatic logic [REG_W-1:0] ptr_step(input logic [REG_W-1:0] ptr,
                                                input logic [REG_W-1:0] first,
                                                input logic [REG_W-1:0] last,
                                                input logic [REG_W-1:0] unit);
    return (ptr == last) ? first : ptr + unit;
  endfunction

  // replace one 16-bit half, then apply an alignment mask
  function automatic logic [REG_W-1:0] merge_half(input logic [REG_W-1:0] old,
                                                  input logic [BUS_W-1:0] d,
                                                  input logic             hi,
                                                  input logic [REG_W-1:0] keep);
    logic [REG_W-1:0] r;
    r = hi ? {d, old[BUS_W-1:0]} : {old[REG_W-1:BUS_W], d};
    return r & keep;
  endfunction

  function automatic logic [BUS_W-1:0] half_of(input logic [REG_W-1:0] v,
                                               input logic             hi);
    return hi ? v[REG_W-1:BUS_W] : v[BUS_W-1:0];
  endfunction

  // address matches an exact 16-bit half (byte bit ignored by caller)
  function automatic logic sel_half(input logic [REG_AW-1:0] a,
                                    input logic [REG_AW-1:0] ofs);
    return a[REG_AW-1:1] == ofs[REG_AW-1:1];
  endfunction

  function automatic logic sel_word(input logic [REG_AW-1:0] a,
                                    input logic [REG_AW-1:0] ofs);
    return a[REG_AW-1:2] == ofs[REG_AW-1:2];
  endfunction
endpackage

// File: rtl/cfp_ptr_unit.sv
module cfp_ptr_unit
  import cfp_pkg::*;
#(
  parameter int UNIT_LG2 = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_lo,
  input  logic             sw_hi,
  input  logic [BUS_W-1:0] wdata,
  input  logic             step,
  input  logic [REG_W-1:0] first,
  input  logic [REG_W-1:0] last,
  output logic [REG_W-1:0] ptr
);
  localparam logic [REG_W-1:0] UNIT       = REG_W'(1) << UNIT_LG2;
  localparam logic [REG_W-1:0] ALIGN_MASK = ~(UNIT - REG_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr <= '0;
    else if (sw_lo || sw_hi)
      ptr <= merge_half(ptr, wdata, sw_hi, ALIGN_MASK);
    else if (step)
      ptr <= ptr_step(ptr, first, last, UNIT);
  end
endmodule

// File: rtl/cfp_flags.sv
module cfp_flags
  import cfp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] count,
  input  logic [REG_W-1:0] hiwm,
  input  logic [REG_W-1:0] lowm,
  input  logic             bp_hit_now,
  input  logic             clr_ovf,
  input  logic             clr_udf,
  input  logic             bp_release,
  output logic             ovf,
  output logic             udf,
  output logic             bp
);
  logic over_now, under_now;
  assign over_now  = count > hiwm;
  assign under_now = count < lowm;

  // a live condition outranks the software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf <= 1'b0;
      udf <= 1'b0;
      bp  <= 1'b0;
    end else begin
      ovf <= (ovf & ~clr_ovf) | over_now;
      udf <= (udf & ~clr_udf) | under_now;
      if (bp_release)
        bp <= 1'b0;
      else if (bp_hit_now)
        bp <= 1'b1;
    end
  end
endmodule

// File: rtl/cmd_fifo_ptr_ctrl.sv
module cmd_fifo_ptr_ctrl
  import cfp_pkg::*;
#(
  parameter int UNIT_LG2 = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  input  logic              cpu_push,
  input  logic              rd_req,
  output logic              rd_grant,
  output logic [REG_W-1:0]  rd_addr,
  input  logic              parser_idle,
  output logic              ovf_flag,
  output logic              udf_flag,
  output logic              bp_flag,
  output logic              irq
);
  localparam int NSLOT   = 5;
  localparam int SL_BASE = 0;
  localparam int SL_TOP  = 1;
  localparam int SL_WR   = 2;
  localparam int SL_RD   = 3;
  localparam int SL_BRK  = 4;
  localparam logic [REG_AW-1:0] SLOT_OFS [NSLOT] =
    '{OFS_BASE, OFS_TOP, OFS_WPTR, OFS_RPTR, OFS_BRK};
  localparam logic [REG_W-1:0] FULL_MASK = '1;

  // named internal events
  logic                          wr_ok;
  logic                          sw_ctrl, sw_clr;
  logic                          sw_cnt_lo, sw_cnt_hi, sw_cnt;
  logic                          sw_wp;
  logic                          push_acc;
  logic                          bp_hit_now;
  logic                          bp_release;
  logic                          rd_idle, cmd_idle;
  logic [CTRL_W-1:0]             ctrl_q;
  logic [REG_W-1:0]              hiwm_q, lowm_q, cnt_q;
  logic [NSLOT-1:0]              slot_lo, slot_hi, slot_step;
  logic [NSLOT-1:0][REG_W-1:0]   slot_q;
  logic [BUS_W-1:0]              status;

  assign wr_ok     = reg_wr & ~reg_addr[0];
  assign sw_ctrl   = wr_ok && sel_half(reg_addr, OFS_CTRL);
  assign sw_clr    = wr_ok && sel_half(reg_addr, OFS_CLR);
  assign sw_cnt_lo = wr_ok && sel_half(reg_addr, OFS_CNT);
  assign sw_cnt_hi = wr_ok && sel_half(reg_addr, OFS_CNT + 8'd2);
  assign sw_cnt    = sw_cnt_lo | sw_cnt_hi;
  assign sw_wp     = slot_lo[SL_WR] | slot_hi[SL_WR];

  assign push_acc   = cpu_push & ctrl_q[CB_WPINC];
  assign bp_hit_now = ctrl_q[CB_BPEN] && (slot_q[SL_RD] == slot_q[SL_BRK]);
  assign bp_release = sw_ctrl && !reg_wdata[CB_BPEN];
  assign rd_grant   = rd_req && ctrl_q[CB_RDEN] && (cnt_q != '0)
                      && !bp_hit_now && !bp_flag;
  assign rd_addr    = slot_q[SL_RD];

  // address registers: one aligned pointer unit per slot
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign slot_lo[g]   = wr_ok && sel_half(reg_addr, SLOT_OFS[g]);
    assign slot_hi[g]   = wr_ok && sel_half(reg_addr, SLOT_OFS[g] + 8'd2);
    assign slot_step[g] = (g == SL_WR) ? push_acc :
                          (g == SL_RD) ? rd_grant : 1'b0;
    cfp_ptr_unit #(.UNIT_LG2(UNIT_LG2)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .sw_lo (slot_lo[g]),
      .sw_hi (slot_hi[g]),
      .wdata (reg_wdata),
      .step  (slot_step[g]),
      .first (slot_q[SL_BASE]),
      .last  (slot_q[SL_TOP]),
      .ptr   (slot_q[g])
    );
  end

  // control, watermarks and count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      hiwm_q <= '0;
      lowm_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (sw_ctrl)
        ctrl_q <= reg_wdata[CTRL_W-1:0];
      if (wr_ok && sel_word(reg_addr, OFS_HIWM))
        hiwm_q <= merge_half(hiwm_q, reg_wdata, reg_addr[1], FULL_MASK);
      if (wr_ok && sel_word(reg_addr, OFS_LOWM))
        lowm_q <= merge_half(lowm_q, reg_wdata, reg_addr[1], FULL_MASK);
      if (sw_cnt)
        cnt_q <= merge_half(cnt_q, reg_wdata, sw_cnt_hi, FULL_MASK);
      else if (push_acc && !rd_grant)
        cnt_q <= cnt_q + REG_W'(1);
      else if (!push_acc && rd_grant)
        cnt_q <= cnt_q - REG_W'(1);
    end
  end

  cfp_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .count      (cnt_q),
    .hiwm       (hiwm_q),
    .lowm       (lowm_q),
    .bp_hit_now (bp_hit_now),
    .clr_ovf    (sw_clr & reg_wdata[CL_OVF]),
    .clr_udf    (sw_clr & reg_wdata[CL_UDF]),
    .bp_release (bp_release),
    .ovf        (ovf_flag),
    .udf        (udf_flag),
    .bp         (bp_flag)
  );

  assign rd_idle  = ~rd_req;
  assign cmd_idle = rd_idle & parser_idle & (cnt_q == '0);
  assign status   = BUS_W'({bp_flag, cmd_idle, rd_idle, udf_flag, ovf_flag});

  assign irq = (ovf_flag & ctrl_q[CB_OVFIE]) |
               (udf_flag & ctrl_q[CB_UDFIE]) |
               (bp_flag  & ctrl_q[CB_BPIE]);

  always_comb begin
    reg_rdata = '0;
    if (sel_half(reg_addr, OFS_STAT))
      reg_rdata = status;
    else if (sel_half(reg_addr, OFS_CTRL))
      reg_rdata = BUS_W'(ctrl_q);
    else if (sel_word(reg_addr, OFS_HIWM))
      reg_rdata = half_of(hiwm_q, reg_addr[1]);
    else if (sel_word(reg_addr, OFS_LOWM))
      reg_rdata = half_of(lowm_q, reg_addr[1]);
    else if (sel_word(reg_addr, OFS_CNT))
      reg_rdata = half_of(cnt_q, reg_addr[1]);
    for (int i = 0; i < NSLOT; i++)
      if (sel_word(reg_addr, SLOT_OFS[i]))
        reg_rdata = half_of(slot_q[i], reg_addr[1]);
  end
endmodule

// File: rtl/cfp_checker.sv
module cfp_checker
  import cfp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             push_acc,
  input logic             rd_grant,
  input logic             sw_cnt,
  input logic             sw_wp,
  input logic [REG_W-1:0] cnt_q,
  input logic [REG_W-1:0] wr_ptr,
  input logic [REG_W-1:0] first,
  input logic [REG_W-1:0] last,
  input logic [REG_W-1:0] hiwm,
  input logic [REG_W-1:0] lowm,
  input logic             ovf,
  input logic             udf,
  input logic             bp,
  input logic             bp_release
);
  p_push_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push_acc && !rd_grant && !sw_cnt |=> cnt_q == $past(cnt_q) + REG_W'(1));

  p_pop_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !push_acc && rd_grant && !sw_cnt |=> cnt_q == $past(cnt_q) - REG_W'(1));

  p_both_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push_acc && rd_grant && !sw_cnt |=> cnt_q == $past(cnt_q));

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push_acc && (wr_ptr == last) && !sw_wp |=> wr_ptr == $past(first));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q > hiwm |=> ovf);

  p_underflow_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < lowm |=> udf);

  p_bp_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bp |-> !rd_grant);

  p_bp_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bp && !bp_release |=> bp);
endmodule

bind cmd_fifo_ptr_ctrl cfp_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .push_acc   (push_acc),
  .rd_grant   (rd_grant),
  .sw_cnt     (sw_cnt),
  .sw_wp      (sw_wp),
  .cnt_q      (cnt_q),
  .wr_ptr     (slot_q[SL_WR]),
  .first      (slot_q[SL_BASE]),
  .last       (slot_q[SL_TOP]),
  .hiwm       (hiwm_q),
  .lowm       (lowm_q),
  .ovf        (ovf_flag),
  .udf        (udf_flag),
  .bp         (bp_flag),
  .bp_release (bp_release)
);

// File: tb/tb_cmd_fifo_ptr_ctrl.sv
`timescale 1ns/1ps
module tb_cmd_fifo_ptr_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        cpu_push = 1'b0;
  logic        rd_req = 1'b0;
  logic        rd_grant;
  logic [31:0] rd_addr;
  logic        parser_idle = 1'b1;
  logic        ovf_flag, udf_flag, bp_flag, irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cmd_fifo_ptr_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_push(cpu_push),
    .rd_req(rd_req), .rd_grant(rd_grant), .rd_addr(rd_addr),
    .parser_idle(parser_idle), .ovf_flag(ovf_flag), .udf_flag(udf_flag),
    .bp_flag(bp_flag), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, {16'h0, reg_rdata}, {16'h0, exp});
  endtask

  task automatic push1();
    @(negedge clk); cpu_push = 1'b1;
    @(negedge clk); cpu_push = 1'b0;
  endtask

  task automatic pop1(input logic exp_grant, input string req);
    @(negedge clk); rd_req = 1'b1;
    #1 chk(req, {31'h0, rd_grant}, {31'h0, exp_grant});
    @(negedge clk); rd_req = 1'b0;
  endtask

  task automatic both1();
    @(negedge clk); cpu_push = 1'b1; rd_req = 1'b1;
    #1 chk("R6", {31'h0, rd_grant}, 32'h1);
    @(negedge clk); cpu_push = 1'b0; rd_req = 1'b0;
  endtask

  // {read?, byte offset, data}: read entries compare, write entries store
  localparam int NV = 22;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'h20, 16'h1000}, {1'b0, 8'h22, 16'h0000},
    {1'b0, 8'h24, 16'h1060}, {1'b0, 8'h26, 16'h0000},
    {1'b0, 8'h28, 16'h0002}, {1'b0, 8'h2C, 16'h0001},
    {1'b0, 8'h34, 16'h1000}, {1'b0, 8'h38, 16'h1000},
    {1'b0, 8'h3C, 16'h1234}, {1'b0, 8'h3E, 16'hABCD},
    {1'b1, 8'h20, 16'h1000}, {1'b1, 8'h24, 16'h1060},
    {1'b1, 8'h28, 16'h0002}, {1'b1, 8'h2C, 16'h0001},
    {1'b1, 8'h34, 16'h1000}, {1'b1, 8'h38, 16'h1000},
    {1'b1, 8'h3C, 16'h1220}, {1'b1, 8'h3E, 16'hABCD},
    {1'b1, 8'h04, 16'h0000}, {1'b1, 8'h30, 16'h0000},
    {1'b0, 8'h3E, 16'h0000}, {1'b0, 8'h3C, 16'h1060}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk(8'h02, 16'h0010, "R1");
    rd_chk(8'h00, 16'h000C, "R1");
    rd_chk(8'h30, 16'h0000, "R1");
    rd_chk(8'h34, 16'h0000, "R1");
    chk("R1", {31'h0, irq}, 32'h0);

    // R2 register map walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) rd_chk(VEC[i][23:16], VEC[i][15:0], "R2");
      else            wr_reg(VEC[i][23:16], VEC[i][15:0]);
    end

    // R3 / R4 push path
    push1();
    rd_chk(8'h34, 16'h1020, "R3");
    rd_chk(8'h30, 16'h0001, "R3");
    push1(); push1();
    rd_chk(8'h34, 16'h1060, "R3");
    push1();
    rd_chk(8'h34, 16'h1000, "R4");
    rd_chk(8'h30, 16'h0004, "R3");
    rd_chk(8'h00, 16'h0007, "R7");
    chk("R11", {31'h0, irq}, 32'h0);
    wr_reg(8'h02, 16'h0000);
    push1();
    rd_chk(8'h34, 16'h1000, "R3");
    rd_chk(8'h30, 16'h0004, "R3");

    // R5 read path
    pop1(1'b0, "R5");
    rd_chk(8'h30, 16'h0004, "R5");
    wr_reg(8'h02, 16'h0001);
    chk("R5", rd_addr, 32'h0000_1000);
    pop1(1'b1, "R5");
    rd_chk(8'h38, 16'h1020, "R5");
    rd_chk(8'h30, 16'h0003, "R5");
    pop1(1'b1, "R5"); pop1(1'b1, "R5");
    pop1(1'b1, "R4");
    rd_chk(8'h38, 16'h1000, "R4");
    rd_chk(8'h30, 16'h0000, "R5");
    pop1(1'b0, "R5");

    // R6 push and grant in one cycle
    wr_reg(8'h02, 16'h0011);
    push1();
    both1();
    rd_chk(8'h30, 16'h0001, "R6");
    rd_chk(8'h34, 16'h1040, "R6");
    rd_chk(8'h38, 16'h1020, "R6");

    // R7 sticky and clear
    rd_chk(8'h00, 16'h0007, "R7");
    wr_reg(8'h04, 16'h0003);
    rd_chk(8'h00, 16'h0004, "R7");

    // R8 underflow, clear while condition holds, R11 enable
    pop1(1'b1, "R8");
    rd_chk(8'h00, 16'h000E, "R8");
    chk("R11", {31'h0, irq}, 32'h0);
    wr_reg(8'h02, 16'h0019);
    chk("R11", {31'h0, irq}, 32'h1);
    wr_reg(8'h04, 16'h0002);
    rd_chk(8'h00, 16'h000E, "R8");

    // R9 breakpoint at 0x1060
    wr_reg(8'h02, 16'h0033);
    push1(); push1();
    pop1(1'b1, "R9");
    pop1(1'b0, "R9");
    rd_chk(8'h00, 16'h0016, "R9");
    chk("R11", {31'h0, irq}, 32'h1);
    wr_reg(8'h04, 16'h0003);
    rd_chk(8'h00, 16'h0014, "R9");
    wr_reg(8'h02, 16'h0031);
    rd_chk(8'h00, 16'h0004, "R9");
    chk("R11", {31'h0, irq}, 32'h0);
    pop1(1'b1, "R9");

    // R10 idle bits
    parser_idle = 1'b0;
    rd_chk(8'h00, 16'h0006, "R10");
    parser_idle = 1'b1;
    rd_req = 1'b1;
    rd_chk(8'h00, 16'h0002, "R10");
    rd_req = 1'b0;
    rd_chk(8'h00, 16'h000E, "R10");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: act=timeout exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule